// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block runs one IDE DMA data transfer between a drive and a DMA channel that works through a chain of descriptors. A start request loads a byte budget, clears a running byte index and arms the sequencer. The budget is the sector count times 512 for a hard disk, or the packet transfer size for an optical (ATAPI) drive. The request also pulses a kick to the channel.

The channel then offers chunks, each a buffer address and a length. For each chunk the sequencer decides one of these outcomes:
- stall the channel, because no transfer is armed;
- finish the transfer;
- end only the current DMA step;
- copy non-block ATAPI data directly;
- consume the chunk and issue one request to the storage back-end.

A storage request goes out with a 64-bit byte offset and a direction. The back-end answers with a one-cycle done pulse and an error bit. On each done pulse the sequencer evaluates its state again, as if the channel had offered an empty chunk.

Each ending reports to the drive logic through one pulse and to the channel through `end_o`:
- hard-disk completion raises the drive interrupt with a READY|SEEK status;
- ATAPI completion signals command success;
- a storage error is reported through the error path of the drive kind.

Top module: `ide_dma_seq`

## Requirements
- R1: On `start_i`, the next cycle shows `kick_o`=1, `active_o`=1 and `index_o`=0. It also shows `remain_o` = `nsect_i`×512 when `atapi_i`=0, or `pkt_size_i` when `atapi_i`=1.
- R2: A chunk offered while `active_o`=0 produces a one-cycle `stall_o`. It produces no `take_o`, no `st_req_o` and no change of `remain_o` or `index_o`.
- R3: A chunk offered while active and while `remain_o` ≤ 0 (taken as signed) ends the transfer in the next cycle. For a hard disk this pulses `drv_irq_o`; for ATAPI it pulses `atapi_ok_o`. In both cases it pulses `end_o` and clears `active_o`.
- R4: A chunk of length 0 offered while active with `remain_o` > 0 pulses only `end_o`. It leaves `remain_o`, `index_o` and `active_o` unchanged.
- R5: The storage offset `st_off_o` is (sector << 9) + index for a hard disk, and (LBA << 11) + index for ATAPI. The index used is the value before the chunk is added.
- R6: An accepted chunk pulses `take_o` and `st_req_o` with `st_addr_o`/`st_len_o` equal to the chunk. It subtracts the length from `remain_o` and adds it to `index_o`.
- R7: An ATAPI transfer whose LBA is all ones is non-block. A chunk then pulses `copy_o`, `take_o`, `atapi_ok_o` and `end_o` with `copy_len_o` = min(remain, length). It sets `remain_o` to that value, clears `active_o` and issues no storage request.
- R8: For a hard disk, the command code decides the request. Code 0 reads (`st_wr_o`=0, `st_trim_o`=0). Code 1 writes (`st_wr_o`=1, `st_trim_o`=0). Code 2 trims (`st_wr_o`=1, `st_trim_o`=1). Code 3 is illegal: it pulses `illegal_o` and `end_o`, clears `active_o` and issues no request.
- R9: A done pulse with `st_err_i`=1 pulses `dma_err_o` for a hard disk or `atapi_err_o` for ATAPI, together with `end_o`, and clears `active_o`.
- R10: A done pulse without error finishes the transfer as in R3 when `remain_o` ≤ 0. Otherwise it pulses only `end_o` and stays active.
- R11: While a storage request is outstanding, offered chunks are ignored: no `take_o`, no `st_req_o`, and `remain_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start a transfer |
| atapi_i | input | 1 | 1 = optical drive, 0 = hard disk |
| nsect_i | input | NS_W | Sector count (hard disk) |
| pkt_size_i | input | CNT_W | Packet transfer size in bytes (ATAPI) |
| sector_i | input | LBA_W | Current sector number (hard disk) |
| lba_i | input | LBA_W | Block address (ATAPI); all ones = non-block |
| cmd_i | input | 2 | 0 read, 1 write, 2 trim, 3 illegal |
| kick_o | output | 1 | Kick the DMA channel |
| active_o | output | 1 | Transfer armed |
| remain_o | output | CNT_W | Remaining byte count (signed) |
| index_o | output | CNT_W | Running byte index |
| chunk_valid_i | input | 1 | Channel offers a chunk |
| chunk_addr_i | input | ADDR_W | Chunk buffer address |
| chunk_len_i | input | CNT_W | Chunk length in bytes |
| take_o | output | 1 | Chunk consumed (length zeroed) |
| stall_o | output | 1 | Channel marked not processing |
| st_req_o | output | 1 | Storage request pulse |
| st_wr_o | output | 1 | Request is to-device |
| st_trim_o | output | 1 | Request is a trim |
| st_off_o | output | OFF_W | Storage byte offset |
| st_addr_o | output | ADDR_W | Buffer address of request |
| st_len_o | output | CNT_W | Length of request |
| st_done_i | input | 1 | Storage done pulse |
| st_err_i | input | 1 | Storage error with done |
| copy_o | output | 1 | Direct copy pulse |
| copy_len_o | output | CNT_W | Bytes to copy directly |
| drv_irq_o | output | 1 | Hard-disk done: READY\|SEEK and interrupt |
| atapi_ok_o | output | 1 | ATAPI command success |
| dma_err_o | output | 1 | Hard-disk DMA error |
| atapi_err_o | output | 1 | ATAPI I/O error |
| illegal_o | output | 1 | Illegal command kind |
| end_o | output | 1 | DMA step ended, drive inactive |

## Verification
Every result is registered once. A start, chunk or done event sampled at one rising edge shows on the outputs during the following cycle, and every pulse lasts exactly that one cycle. The bench drives an event just after an edge and removes it one nanosecond after the next edge. It then reads the outputs at that point, inside the single cycle where the pulse is due. A read taken there also confirms that state such as `remain_o` has settled, and that it has not moved on an ignored event.

// File: rtl/ide_dma_seq.sv
module ide_dma_seq #(
  parameter int CNT_W  = 32,
  parameter int LBA_W  = 48,
  parameter int OFF_W  = 64,
  parameter int ADDR_W = 32,
  parameter int NS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              atapi_i,
  input  logic [NS_W-1:0]   nsect_i,
  input  logic [CNT_W-1:0]  pkt_size_i,
  input  logic [LBA_W-1:0]  sector_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic [1:0]        cmd_i,
  output logic              kick_o,
  output logic              active_o,
  output logic [CNT_W-1:0]  remain_o,
  output logic [CNT_W-1:0]  index_o,
  input  logic              chunk_valid_i,
  input  logic [ADDR_W-1:0] chunk_addr_i,
  input  logic [CNT_W-1:0]  chunk_len_i,
  output logic              take_o,
  output logic              stall_o,
  output logic              st_req_o,
  output logic              st_wr_o,
  output logic              st_trim_o,
  output logic [OFF_W-1:0]  st_off_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [CNT_W-1:0]  st_len_o,
  input  logic              st_done_i,
  input  logic              st_err_i,
  output logic              copy_o,
  output logic [CNT_W-1:0]  copy_len_o,
  output logic              drv_irq_o,
  output logic              atapi_ok_o,
  output logic              dma_err_o,
  output logic              atapi_err_o,
  output logic              illegal_o,
  output logic              end_o
);
  localparam int SECT_SH = 9;
  localparam int BLK_SH  = 11;
  localparam logic [1:0] CMD_RD = 2'd0, CMD_WR = 2'd1, CMD_TRIM = 2'd2;

  logic             atapi_q, wait_q;
  logic [LBA_W-1:0] sector_q, lba_q;
  logic [1:0]       cmd_q;

  wire rem_le0 = $signed(remain_o) <= 0;
  wire nonblk  = atapi_q && (&lba_q);
  wire [OFF_W-1:0] base_off = atapi_q ? (OFF_W'(lba_q) << BLK_SH) : (OFF_W'(sector_q) << SECT_SH);
  wire [OFF_W-1:0] cur_off  = base_off + OFF_W'(index_o);
  wire [CNT_W-1:0] clamp    = (chunk_len_i < remain_o) ? chunk_len_i : remain_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {atapi_q, wait_q, active_o, kick_o, take_o, stall_o, st_req_o, st_wr_o, st_trim_o} <= '0;
      {copy_o, drv_irq_o, atapi_ok_o, dma_err_o, atapi_err_o, illegal_o, end_o} <= '0;
      sector_q <= '0; lba_q <= '0; cmd_q <= '0;
      remain_o <= '0; index_o <= '0; st_off_o <= '0; st_addr_o <= '0;
      st_len_o <= '0; copy_len_o <= '0;
    end else begin
      {kick_o, take_o, stall_o, st_req_o, copy_o} <= '0;
      {drv_irq_o, atapi_ok_o, dma_err_o, atapi_err_o, illegal_o, end_o} <= '0;
      if (start_i) begin
        atapi_q  <= atapi_i;
        sector_q <= sector_i;
        lba_q    <= lba_i;
        cmd_q    <= cmd_i;
        index_o  <= '0;
        remain_o <= atapi_i ? pkt_size_i : (CNT_W'(nsect_i) << SECT_SH);
        active_o <= 1'b1;
        wait_q   <= 1'b0;
        kick_o   <= 1'b1;
      end else if (wait_q) begin
        if (st_done_i) begin
          wait_q <= 1'b0;
          end_o  <= 1'b1;
          if (st_err_i) begin
            dma_err_o   <= !atapi_q;
            atapi_err_o <= atapi_q;
            active_o    <= 1'b0;
          end else if (rem_le0) begin
            drv_irq_o  <= !atapi_q;
            atapi_ok_o <= atapi_q;
            active_o   <= 1'b0;
          end
        end
      end else if (chunk_valid_i) begin
        if (!active_o) begin
          stall_o <= 1'b1;
        end else if (rem_le0) begin
          drv_irq_o  <= !atapi_q;
          atapi_ok_o <= atapi_q;
          active_o   <= 1'b0;
          end_o      <= 1'b1;
        end else if (chunk_len_i == '0) begin
          end_o <= 1'b1;
        end else if (nonblk) begin
          remain_o   <= clamp;
          copy_len_o <= clamp;
          copy_o     <= 1'b1;
          take_o     <= 1'b1;
          atapi_ok_o <= 1'b1;
          active_o   <= 1'b0;
          end_o      <= 1'b1;
        end else if (!atapi_q && cmd_q == 2'd3) begin
          illegal_o <= 1'b1;
          active_o  <= 1'b0;
          end_o     <= 1'b1;
        end else begin
          st_off_o  <= cur_off;
          st_addr_o <= chunk_addr_i;
          st_len_o  <= chunk_len_i;
          st_wr_o   <= !atapi_q && (cmd_q == CMD_WR || cmd_q == CMD_TRIM);
          st_trim_o <= !atapi_q && (cmd_q == CMD_TRIM);
          remain_o  <= remain_o - chunk_len_i;
          index_o   <= index_o + chunk_len_i;
          take_o    <= 1'b1;
          st_req_o  <= 1'b1;
          wait_q    <= 1'b1;
        end
      end
    end
  end

  // R1
  kick_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_o |-> active_o && index_o == '0);
  // R2
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> !active_o && !take_o && !st_req_o);
  // R3
  finish_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_irq_o || atapi_ok_o) |-> end_o && !active_o);
  // R6
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_req_o |=> !st_req_o);
  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_irq_o, atapi_ok_o, dma_err_o, atapi_err_o, illegal_o}));
  // R11
  held_remain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !st_done_i && !start_i) |=> $stable(remain_o) && !take_o);
endmodule

// File: tb/ide_dma_seq_test.sv
module ide_dma_seq_test;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, atapi_i = 0;
  logic [15:0] nsect_i = 0;
  logic [31:0] pkt_size_i = 0;
  logic [47:0] sector_i = 0, lba_i = 0;
  logic [1:0] cmd_i = 0;
  logic chunk_valid_i = 0;
  logic [31:0] chunk_addr_i = 0, chunk_len_i = 0;
  logic st_done_i = 0, st_err_i = 0;
  logic kick_o, active_o, take_o, stall_o, st_req_o, st_wr_o, st_trim_o, copy_o;
  logic drv_irq_o, atapi_ok_o, dma_err_o, atapi_err_o, illegal_o, end_o;
  logic [31:0] remain_o, index_o, st_len_o, copy_len_o, st_addr_o;
  logic [63:0] st_off_o;

  int total = 0, bad = 0;

  ide_dma_seq uut (.*);

  always #(CLK_NS/2) clk = ~clk;

  localparam int NV = 3;
  localparam longint V_LEN [NV] = '{512, 1024, 512};
  localparam longint V_OFF [NV] = '{5120, 5632, 6656};
  localparam longint V_REM [NV] = '{1536, 512, 0};

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(logic at, int ns, int pkt, longint sec, longint lba, int cmd);
    @(posedge clk); #1;
    start_i = 1; atapi_i = at; nsect_i = 16'(ns); pkt_size_i = 32'(pkt);
    sector_i = 48'(sec); lba_i = 48'(lba); cmd_i = 2'(cmd);
    @(posedge clk); #1;
    start_i = 0;
  endtask

  task automatic offer(int len, int addr);
    @(posedge clk); #1;
    chunk_valid_i = 1; chunk_len_i = 32'(len); chunk_addr_i = 32'(addr);
    @(posedge clk); #1;
    chunk_valid_i = 0;
  endtask

  task automatic done(logic err);
    @(posedge clk); #1;
    st_done_i = 1; st_err_i = err;
    @(posedge clk); #1;
    st_done_i = 0; st_err_i = 0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 reset active", active_o, 0);
    chk("R1 reset remain", remain_o, 0);

    offer(64, 32'h100);
    chk("R2 stall", stall_o, 1);
    chk("R2 no take", take_o, 0);
    chk("R2 no req", st_req_o, 0);

    do_start(0, 4, 0, 10, 0, 1);
    chk("R1 kick", kick_o, 1);
    chk("R1 active", active_o, 1);
    chk("R1 remain hd", remain_o, 2048);
    chk("R1 index", index_o, 0);
    for (int i = 0; i < NV; i++) begin
      offer(int'(V_LEN[i]), 32'h1000 + i);
      chk("R6 take", take_o, 1);
      chk("R6 req", st_req_o, 1);
      chk("R6 addr", st_addr_o, 32'h1000 + i);
      chk("R6 len", st_len_o, V_LEN[i]);
      chk("R5 hd offset", st_off_o, V_OFF[i]);
      chk("R8 write dir", st_wr_o, 1);
      chk("R8 write no trim", st_trim_o, 0);
      chk("R6 remain", remain_o, V_REM[i]);
      offer(32, 32'h2000);
      chk("R11 ignored take", take_o, 0);
      chk("R11 ignored remain", remain_o, V_REM[i]);
      done(0);
      chk("R10 end", end_o, 1);
      chk("R10 finish irq", drv_irq_o, (V_REM[i] == 0) ? 1 : 0);
      chk("R10 active", active_o, (V_REM[i] == 0) ? 0 : 1);
    end

    do_start(0, 1, 0, 0, 0, 0);
    offer(0, 0);
    chk("R4 end", end_o, 1);
    chk("R4 remain", remain_o, 512);
    chk("R4 active", active_o, 1);
    chk("R4 no take", take_o, 0);
    offer(512, 32'h40);
    chk("R8 read dir", st_wr_o, 0);
    done(1);
    chk("R9 hd err", dma_err_o, 1);
    chk("R9 end", end_o, 1);
    chk("R9 inactive", active_o, 0);

    do_start(0, 0, 0, 0, 0, 0);
    offer(64, 0);
    chk("R3 hd irq", drv_irq_o, 1);
    chk("R3 end", end_o, 1);
    chk("R3 no req", st_req_o, 0);
    chk("R3 inactive", active_o, 0);

    do_start(1, 0, 4096, 0, 3, 0);
    chk("R1 remain atapi", remain_o, 4096);
    offer(2048, 0);
    chk("R5 atapi offset 0", st_off_o, 6144);
    done(0);
    chk("R10 step end", end_o, 1);
    offer(2048, 0);
    chk("R5 atapi offset 1", st_off_o, 8192);
    done(0);
    chk("R10 atapi ok", atapi_ok_o, 1);
    chk("R10 atapi inactive", active_o, 0);

    do_start(1, 0, 2048, 0, 5, 0);
    offer(1024, 0);
    done(1);
    chk("R9 atapi err", atapi_err_o, 1);
    chk("R9 no hd err", dma_err_o, 0);

    do_start(1, 0, 0, 0, 5, 0);
    offer(16, 0);
    chk("R3 atapi ok", atapi_ok_o, 1);

    do_start(1, 0, 100, 0, 48'hFFFF_FFFF_FFFF, 0);
    offer(512, 0);
    chk("R7 copy", copy_o, 1);
    chk("R7 clamp remain", copy_len_o, 100);
    chk("R7 ok", atapi_ok_o, 1);
    chk("R7 no req", st_req_o, 0);
    chk("R7 inactive", active_o, 0);
    do_start(1, 0, 600, 0, 48'hFFFF_FFFF_FFFF, 0);
    offer(256, 0);
    chk("R7 clamp len", copy_len_o, 256);
    chk("R7 remain", remain_o, 256);

    do_start(0, 2, 0, 1, 0, 2);
    offer(512, 0);
    chk("R8 trim dir", st_wr_o, 1);
    chk("R8 trim flag", st_trim_o, 1);
    done(0);
    do_start(0, 2, 0, 1, 0, 3);
    offer(512, 0);
    chk("R8 illegal", illegal_o, 1);
    chk("R8 illegal no req", st_req_o, 0);
    chk("R8 illegal end", end_o, 1);
    chk("R8 illegal inactive", active_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule